// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Status Flags

This block performs the data operations of a small accumulator-style processor on byte operands. Each request presents an accumulator byte, a second operand byte, the incoming carry, auxiliary-carry and overflow flags, and an operation select. One clock later the block returns a new accumulator byte, a second result byte, the updated flags, an even-parity bit, a zero indication and a not-equal indication for compare-and-branch decisions.

The block handles addition with and without carry, subtraction with borrow, increment and decrement, bitwise logic, complement and clear, four kinds of rotate, nibble swap, decimal correction after a packed-BCD addition, unsigned multiply and divide with a paired high/low result, and unsigned compare. A flag that an operation does not define comes back exactly as it went in, so the caller can write all flags back on every operation. Instruction decoding, operand fetch and program flow are left to the surrounding logic.

Top module: `byte_alu`

## Requirements
- R1: While `rst_n` is low all outputs are 0. A request is taken on a rising edge where `in_valid` is 1; its results appear on the outputs after that edge, with `out_valid` 1 for exactly that one cycle, and `out_valid` is 0 after an edge with no request.
- R2: Select 0 adds the operand to the accumulator and select 1 also adds the carry input; carry out is the carry from bit 7, auxiliary carry is the carry from bit 3, and overflow is 1 when the signed sum leaves -128..+127.
- R3: Select 2 computes accumulator minus operand minus carry input; carry out is 1 on a borrow from bit 8, auxiliary carry is 1 on a borrow into bit 4, and overflow is 1 when the signed difference leaves -128..+127.
- R4: Select 3 adds one and select 4 subtracts one from the accumulator, wrapping modulo 256, with carry, auxiliary carry and overflow passed through unchanged.
- R5: Selects 5, 6, 7 give accumulator AND, OR, XOR operand; select 8 gives the bitwise complement of the accumulator and select 9 gives 00h; all five pass the three flags through unchanged.
- R6: Select 10 rotates left (bit 7 into bit 0) and select 12 rotates right (bit 0 into bit 7), both leaving carry unchanged; select 11 rotates left through carry (carry into bit 0, bit 7 into carry) and select 13 rotates right through carry (carry into bit 7, bit 0 into carry).
- R7: Select 14 exchanges the upper and lower four bits of the accumulator, flags unchanged.
- R8: Select 15 adds 06h when the low nibble exceeds 9 or auxiliary carry is set, then adds 60h when the high nibble of that sum exceeds 9 or carry is set or the first step carried out; carry out is 1 if carry was set or either step carries out of bit 7, and is never cleared by this step.
- R9: Select 16 multiplies accumulator by operand as unsigned values, the product's high byte on `b_out` and low byte on `acc_out`; carry is cleared and overflow is 1 exactly when the product exceeds 255.
- R10: Select 17 divides accumulator by operand as unsigned values, quotient on `acc_out` and remainder on `b_out`, carry cleared and overflow 0; with a zero operand overflow is 1 and both result bytes are unspecified.
- R11: Select 18 compares accumulator with operand as unsigned values: carry is 1 when the accumulator is less, `ne_out` is 1 when they differ, and `acc_out` returns the accumulator unchanged. For every other select `ne_out` is 0.
- R12: For every result, `par_out` makes the count of ones in `acc_out` plus `par_out` even, and `zero_out` is 1 exactly when `acc_out` is 00h.
- R13: For every select except 16 and 17, `b_out` returns the operand byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand (B for multiply/divide) |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result strobe |
| acc_out | output | 8 | Accumulator result |
| b_out | output | 8 | Second result byte |
| cy_out | output | 1 | Carry flag result |
| ac_out | output | 1 | Auxiliary-carry flag result |
| ov_out | output | 1 | Overflow flag result |
| par_out | output | 1 | Even-parity bit of `acc_out` |
| zero_out | output | 1 | `acc_out` equals zero |
| ne_out | output | 1 | Compare found the operands different |

## Verification
Every result, including the flags, parity, zero and not-equal outputs, is due on the rising edge that takes the request and is held until the next edge, so all of them are valid one cycle after the strobe. The bench applies requests on the falling edge, queues the expected outputs computed from the operation definitions, and a monitor compares the head of the queue on each falling edge where `out_valid` is high, half a cycle after the outputs settle. Requests run back to back and with gaps, so the one-cycle strobe and its absence are both observed.

// File: rtl/byte_alu.sv
module byte_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [4:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic       out_valid,
  output logic [7:0] acc_out,
  output logic [7:0] b_out,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out,
  output logic       par_out,
  output logic       zero_out,
  output logic       ne_out
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,
                         OP_INC = 5'd3,  OP_DEC  = 5'd4,  OP_AND  = 5'd5,
                         OP_OR  = 5'd6,  OP_XOR  = 5'd7,  OP_CPL  = 5'd8,
                         OP_CLR = 5'd9,  OP_RL   = 5'd10, OP_RLC  = 5'd11,
                         OP_RR  = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14,
                         OP_DA  = 5'd15, OP_MUL  = 5'd16, OP_DIV  = 5'd17,
                         OP_CMP = 5'd18;

  logic       add_cin;
  logic [8:0] sum9, dif9, da1, da2;
  logic [4:0] sum_lo, dif_lo;
  logic [15:0] prod;
  logic [7:0] quot, rem;
  logic       div_zero, da_c1;

  assign add_cin  = (op_sel == OP_ADDC) ? cy_in : 1'b0;
  assign sum9     = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, add_cin};
  assign sum_lo   = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, add_cin};
  assign dif9     = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cy_in};
  assign dif_lo   = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cy_in};
  assign prod     = {8'd0, acc_in} * {8'd0, opnd_in};
  assign div_zero = (opnd_in == 8'd0);
  assign quot     = div_zero ? acc_in  : acc_in / opnd_in;
  assign rem      = div_zero ? opnd_in : acc_in % opnd_in;
  assign da1      = {1'b0, acc_in} + (((acc_in[3:0] > 4'd9) || ac_in) ? 9'h006 : 9'h000);
  assign da_c1    = cy_in | da1[8];
  assign da2      = {1'b0, da1[7:0]} + (((da1[7:4] > 4'd9) || da_c1) ? 9'h060 : 9'h000);

  logic [7:0] r_a, r_b;
  logic       r_cy, r_ac, r_ov, r_ne;

  always_comb begin
    r_a  = acc_in;
    r_b  = opnd_in;
    r_cy = cy_in;
    r_ac = ac_in;
    r_ov = ov_in;
    r_ne = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADDC: begin
        r_a  = sum9[7:0];
        r_cy = sum9[8];
        r_ac = sum_lo[4];
        r_ov = (acc_in[7] == opnd_in[7]) && (sum9[7] != acc_in[7]);
      end
      OP_SUBB: begin
        r_a  = dif9[7:0];
        r_cy = dif9[8];
        r_ac = dif_lo[4];
        r_ov = (acc_in[7] != opnd_in[7]) && (dif9[7] != acc_in[7]);
      end
      OP_INC:  r_a = acc_in + 8'd1;
      OP_DEC:  r_a = acc_in - 8'd1;
      OP_AND:  r_a = acc_in & opnd_in;
      OP_OR:   r_a = acc_in | opnd_in;
      OP_XOR:  r_a = acc_in ^ opnd_in;
      OP_CPL:  r_a = ~acc_in;
      OP_CLR:  r_a = 8'd0;
      OP_RL:   r_a = {acc_in[6:0], acc_in[7]};
      OP_RR:   r_a = {acc_in[0], acc_in[7:1]};
      OP_RLC: begin
        r_a  = {acc_in[6:0], cy_in};
        r_cy = acc_in[7];
      end
      OP_RRC: begin
        r_a  = {cy_in, acc_in[7:1]};
        r_cy = acc_in[0];
      end
      OP_SWAP: r_a = {acc_in[3:0], acc_in[7:4]};
      OP_DA: begin
        r_a  = da2[7:0];
        r_cy = da_c1 | da2[8];
      end
      OP_MUL: begin
        r_a  = prod[7:0];
        r_b  = prod[15:8];
        r_cy = 1'b0;
        r_ov = (prod[15:8] != 8'd0);
      end
      OP_DIV: begin
        r_a  = quot;
        r_b  = rem;
        r_cy = 1'b0;
        r_ov = div_zero;
      end
      OP_CMP: begin
        r_cy = (acc_in < opnd_in);
        r_ne = (acc_in != opnd_in);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= 8'd0;
      b_out     <= 8'd0;
      cy_out    <= 1'b0;
      ac_out    <= 1'b0;
      ov_out    <= 1'b0;
      par_out   <= 1'b0;
      zero_out  <= 1'b0;
      ne_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out  <= r_a;
        b_out    <= r_b;
        cy_out   <= r_cy;
        ac_out   <= r_ac;
        ov_out   <= r_ov;
        par_out  <= ^r_a;
        zero_out <= (r_a == 8'd0);
        ne_out   <= r_ne;
      end
    end
  end
endmodule

// File: rtl/byte_alu_props.sv
module byte_alu_props (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [4:0] op_sel,
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic       out_valid,
  input logic [7:0] acc_out,
  input logic [7:0] b_out,
  input logic       cy_out,
  input logic       ov_out,
  input logic       par_out,
  input logic       zero_out,
  input logic       ne_out
);
  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_even_parity_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((^{acc_out, par_out}) == 1'b0));

  p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero_out == (acc_out == 8'd0)));

  p_mul_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 5'd16) |-> (!cy_out && (ov_out == (b_out != 8'd0))));

  p_div_identity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 5'd17 && $past(opnd_in) != 8'd0) |->
      (({8'd0, acc_out} * {8'd0, $past(opnd_in)} + {8'd0, b_out} == {8'd0, $past(acc_in)})
       && (b_out < $past(opnd_in)) && !ov_out && !cy_out));

  p_compare_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) == 5'd18) |->
      ((cy_out == ($past(acc_in) < $past(opnd_in))) && (ne_out == ($past(acc_in) != $past(opnd_in)))
       && (acc_out == $past(acc_in))));

  p_ne_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_sel) != 5'd18) |-> !ne_out);
endmodule

bind byte_alu byte_alu_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .acc_in(acc_in), .opnd_in(opnd_in), .out_valid(out_valid),
  .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out),
  .par_out(par_out), .zero_out(zero_out), .ne_out(ne_out)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic cy, ac, ov, par, z, ne, skip_ab;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [4:0] op_sel = 5'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0;
  logic cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic out_valid, cy_out, ac_out, ov_out, par_out, zero_out, ne_out;
  logic [7:0] acc_out, b_out;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .out_valid(out_valid), .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out),
    .ac_out(ac_out), .ov_out(ov_out), .par_out(par_out), .zero_out(zero_out),
    .ne_out(ne_out)
  );

  function automatic exp_t model(input int op, input int a, input int b,
                                 input int c, input int h, input int v);
    exp_t e;
    int r = a, rb = b, sa, sb, t;
    int nc = c, nh = h, nv = v, ne = 0, skip = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        t = (op == 1) ? c : 0;
        r = a + b + t; nc = (r > 255); r = r % 256;
        nh = ((a % 16) + (b % 16) + t) > 15;
        nv = ((sa + sb + t) > 127) || ((sa + sb + t) < -128);
      end
      2: begin
        nc = (a < b + c); r = (a - b - c + 512) % 256;
        nh = (a % 16) < (b % 16) + c;
        nv = ((sa - sb - c) > 127) || ((sa - sb - c) < -128);
      end
      3: r = (a + 1) % 256;
      4: r = (a + 255) % 256;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 255 - a;
      9: r = 0;
      10: r = ((a * 2) % 256) + a / 128;
      11: begin r = ((a * 2) % 256) + c; nc = a / 128; end
      12: r = a / 2 + (a % 2) * 128;
      13: begin r = a / 2 + c * 128; nc = a % 2; end
      14: r = (a % 16) * 16 + a / 16;
      15: begin
        t = a;
        if ((t % 16) > 9 || h) t = t + 6;
        if (t > 255) nc = 1;
        t = t % 256;
        if ((t / 16) > 9 || nc) t = t + 96;
        if (t > 255) nc = 1;
        r = t % 256;
      end
      16: begin t = a * b; r = t % 256; rb = t / 256; nc = 0; nv = (t > 255); end
      17: begin
        nc = 0;
        if (b == 0) begin nv = 1; skip = 1; end
        else begin nv = 0; r = a / b; rb = a % b; end
      end
      18: begin nc = (a < b); ne = (a != b); end
      default: ;
    endcase
    e.a = r[7:0]; e.b = rb[7:0];
    e.cy = nc[0]; e.ac = nh[0]; e.ov = nv[0];
    e.par = ^r[7:0]; e.z = (r[7:0] == 8'd0); e.ne = ne[0]; e.skip_ab = skip[0];
    return e;
  endfunction

  task automatic drive(input int op, input int a, input int b,
                       input int c, input int h, input int v, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op_sel = op[4:0]; acc_in = a[7:0]; opnd_in = b[7:0];
    cy_in = c[0]; ac_in = h[0]; ov_in = v[0];
    exp_q.push_back(model(op, a, b, c, h, v));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      exp_t e;
      string tg;
      logic ok;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected out_valid: actual=1 expected=0");
      end else begin
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        ok = (cy_out == e.cy) && (ac_out == e.ac) && (ov_out == e.ov) &&
             (par_out == e.par) && (zero_out == e.z) && (ne_out == e.ne);
        if (!e.skip_ab) ok = ok && (acc_out == e.a) && (b_out == e.b);
        if (!ok) begin
          bad++;
          $display("FAIL %s actual a=%h b=%h cy=%b ac=%b ov=%b p=%b z=%b ne=%b expected a=%h b=%h cy=%b ac=%b ov=%b p=%b z=%b ne=%b",
                   tg, acc_out, b_out, cy_out, ac_out, ov_out, par_out, zero_out, ne_out,
                   e.a, e.b, e.cy, e.ac, e.ov, e.par, e.z, e.ne);
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL %s out_valid actual=%b expected=0", tag, out_valid);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || acc_out !== 8'd0 || cy_out !== 1'b0 || b_out !== 8'd0) begin
      bad++;
      $display("FAIL R1 reset: actual v=%b a=%h cy=%b b=%h expected v=0 a=00 cy=0 b=00",
               out_valid, acc_out, cy_out, b_out);
    end
    rst_n = 1'b1;
    idle(1);
    check_quiet("R1 idle");

    drive(0, 8'h7F, 8'h01, 0, 0, 0, "R2 add signed overflow");
    drive(0, 8'hFF, 8'h01, 0, 0, 1, "R2 add carry out");
    drive(1, 8'h3A, 8'h05, 1, 0, 0, "R2 addc with carry");
    drive(1, 8'h80, 8'h80, 1, 1, 0, "R2 addc negative overflow");
    idle(1);
    check_quiet("R1 strobe drops");
    drive(2, 8'h00, 8'h01, 0, 0, 0, "R3 subb borrow");
    drive(2, 8'h80, 8'h00, 1, 0, 0, "R3 subb overflow");
    drive(2, 8'h50, 8'h20, 1, 1, 1, "R3 subb plain");
    drive(3, 8'hFF, 8'h00, 1, 1, 1, "R4 inc wraps flags hold");
    drive(4, 8'h00, 8'h12, 0, 1, 0, "R4 dec wraps");
    drive(5, 8'h35, 8'h53, 1, 0, 1, "R5 and");
    drive(6, 8'h35, 8'h53, 0, 1, 0, "R5 or");
    drive(7, 8'h35, 8'h53, 1, 1, 1, "R5 xor");
    drive(8, 8'h0F, 8'h00, 0, 0, 0, "R5 complement");
    drive(9, 8'hA5, 8'h77, 1, 0, 0, "R5 clear");
    drive(10, 8'h81, 8'h00, 0, 0, 0, "R6 rotate left");
    drive(11, 8'h81, 8'h00, 0, 0, 0, "R6 rotate left through carry");
    drive(12, 8'h01, 8'h00, 1, 0, 0, "R6 rotate right");
    drive(13, 8'h02, 8'h00, 1, 0, 0, "R6 rotate right through carry");
    drive(14, 8'h5A, 8'h00, 0, 1, 0, "R7 swap");
    drive(15, 8'h41, 8'h00, 0, 1, 0, "R8 decimal adjust low");
    drive(15, 8'h9A, 8'h00, 0, 0, 0, "R8 decimal adjust to carry");
    drive(15, 8'h15, 8'h00, 1, 0, 0, "R8 decimal adjust carry in");
    drive(16, 8'h10, 8'h20, 1, 0, 0, "R9 multiply overflow");
    drive(16, 8'h03, 8'h04, 1, 0, 1, "R9 multiply small");
    drive(17, 8'd100, 8'd7, 1, 0, 1, "R10 divide");
    drive(17, 8'h42, 8'h00, 1, 0, 0, "R10 divide by zero");
    drive(18, 8'h10, 8'h20, 0, 0, 0, "R11 compare less");
    drive(18, 8'h20, 8'h20, 1, 0, 0, "R11 compare equal");
    drive(18, 8'hF0, 8'h20, 1, 1, 1, "R11 compare greater");
    drive(6, 8'h00, 8'h00, 0, 0, 0, "R12 zero result");
    drive(5, 8'hC3, 8'h9E, 0, 0, 0, "R13 operand passes to b_out");
    idle(1);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R1 results missing: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule